// File: doc/BRIEF.md
# Memory Command-Sequence Unlock Decoder

This block sits in front of a parallel nonvolatile memory that has a flash region and an EEPROM region. It watches the memory bus pins, which are already synchronous to the clock. It turns each completed write cycle into one internal event and decides what that event is. An event can be an ordinary EEPROM data write, or one step of a three-cycle unlock prefix. After a full prefix, the event is the protected data write that the prefix unlocks.

The prefix works as follows:

- Step one writes AAh to the key-A address.
- Step two writes 55h to the key-B address.
- Step three writes the confirm code A0h to the key-A address.

The cycle after the prefix is taken as protected data at whatever address it names. A fixed number of clock cycles after that write, the software-data-protection flag turns on. From then on, plain EEPROM writes are dropped.

A broken or stalled sequence is handled according to the region of the cycle involved:

- **Flash region.** The decoder reports a return to the read-array state.
- **EEPROM region.** The offending cycle is passed through as a single plain write.

Top module: `mem_unlock_decoder`

## Requirements
- R1: A bus write cycle exists only while exactly one of `cs_flash_n`/`cs_eep_n` is low, `we_n` is low and `oe_n` is high. When both selects are low, or when `oe_n` is low, no strobe is produced.
- R2: The address of a cycle is taken when the cycle begins. The data is taken from the last clock of the cycle, just before it ends.
- R3: The ordered cycles (AAh at 5555h), (55h at 2AAAh), (A0h at 5555h) give a one-clock `cmd_valid` pulse. Only address bits [14:0] are compared, and the cycles may mix regions.
- R4: A cycle that is consumed as a prefix step produces no write strobe. At most one of the four output pulses is high in any clock.
- R5: The first cycle after a confirmed prefix gives a one-clock `prot_wr_en` pulse, whatever its address and region. `wr_addr_o`/`wr_data_o` carry that cycle's address and data.
- R6: In the flash region, a wrong address or value at step two or step three gives a one-clock `read_return` pulse and clears the sequence.
- R7: In the EEPROM region, a cycle that breaks a sequence clears the sequence without `read_return`. It is then handled as a plain EEPROM write.
- R8: Once a sequence has started, if `TIMEOUT_CYC` clocks pass with no cycle, the sequence is dropped. `read_return` pulses only if the sequence started in the flash region.
- R9: `sdp_on` rises `WRC_CYC` clocks after a `prot_wr_en` pulse and then stays high until reset.
- R10: While `sdp_on` is high, a plain EEPROM cycle gives no `eep_wr_stb`.
- R11: Reset clears `sdp_on`, the sequence state and all output pulses.
- R12: When `sdp_on` is low, a plain EEPROM cycle gives a one-clock `eep_wr_stb` with its address and data. A plain flash cycle gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cs_flash_n | input | 1 | Flash region select, active low |
| cs_eep_n | input | 1 | EEPROM region select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| bus_addr | input | ADDR_W | Bus address |
| bus_data | input | DATA_W | Bus write data |
| cmd_valid | output | 1 | Prefix confirmed pulse |
| prot_wr_en | output | 1 | Protected write pulse |
| read_return | output | 1 | Flash side returned to read-array pulse |
| eep_wr_stb | output | 1 | Plain EEPROM write pulse |
| wr_addr_o | output | ADDR_W | Address of the last write pulse |
| wr_data_o | output | DATA_W | Data of the last write pulse |
| sdp_on | output | 1 | Software data protection active |

## Verification
The assertions check the following on every cycle:

- No output pulse appears unless a qualified bus cycle has just ended.
- Pulses never coincide.
- A protected write is always preceded by a confirm pulse.
- `sdp_on` never falls outside reset.
- No plain EEPROM strobe is issued while protection is on.

The bench scenarios show the rest, because it depends on data values and on long gaps:

- the exact key addresses and values, including the ignored top address bit;
- the region-specific handling of broken sequences;
- the time-out on each side;
- the delay before protection engages;
- which address and data samples are taken.

// File: rtl/ulk_pkg.sv
package ulk_pkg;
  localparam int unsigned KEY_AW = 15;
  localparam logic [KEY_AW-1:0] KEY_A_ADDR = 15'h5555;
  localparam logic [KEY_AW-1:0] KEY_B_ADDR = 15'h2AAA;
  localparam logic [7:0]        KEY_A_DATA = 8'hAA;
  localparam logic [7:0]        KEY_B_DATA = 8'h55;
  localparam logic [7:0]        CONFIRM_PROT = 8'hA0;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_KEY1  = 2'd1,
    SQ_KEY2  = 2'd2,
    SQ_ARMED = 2'd3
  } seq_st_e;
endpackage

// File: rtl/ulk_bus_capture.sv
module ulk_bus_capture #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_flash_n,
  input  logic          cs_eep_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          evt,
  output logic          evt_eep,
  output logic [AW-1:0] evt_addr,
  output logic [DW-1:0] evt_data
);
  logic          act;
  logic          act_q;
  logic          eep_q, eep_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] data_q, data_n;
  logic          start;

  // qualified write: one select only, strobe low, output enable high
  assign act   = (cs_flash_n ^ cs_eep_n) & ~we_n & oe_n;
  assign start = act & ~act_q;

  always_comb begin
    eep_n  = eep_q;
    addr_n = addr_q;
    data_n = data_q;
    if (start) begin
      eep_n  = ~cs_eep_n;
      addr_n = addr_i;
    end
    if (act) begin
      data_n = data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      eep_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= act;
      if (start) begin
        eep_q  <= eep_n;
        addr_q <= addr_n;
      end
      if (act) begin
        data_q <= data_n;
      end
    end
  end

  assign evt      = act_q & ~act;
  assign evt_eep  = eep_q;
  assign evt_addr = addr_q;
  assign evt_data = data_q;
endmodule

// File: rtl/ulk_seq_decoder.sv
module ulk_seq_decoder
  import ulk_pkg::*;
#(
  parameter int unsigned AW     = 16,
  parameter int unsigned DW     = 8,
  parameter int unsigned TO_CYC = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          evt,
  input  logic          evt_eep,
  input  logic [AW-1:0] evt_addr,
  input  logic [DW-1:0] evt_data,
  input  logic          sdp,
  output logic          cmd_ok,
  output logic          prot_wr,
  output logic          ee_wr,
  output logic          abort,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  localparam int unsigned TW = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TO_CYC - 1);

  seq_st_e       st_q, st_n;
  logic [TW-1:0] cnt_q, cnt_n;
  logic          seq_eep_q, seq_eep_n;
  logic          cmd_n, prot_n, ee_n, abort_n;
  logic          load_n;
  logic [AW-1:0] oaddr_q;
  logic [DW-1:0] odata_q;
  logic          hit_a, hit_b, hit_c;

  assign hit_a = (evt_addr[KEY_AW-1:0] == KEY_A_ADDR) && (evt_data[7:0] == KEY_A_DATA);
  assign hit_b = (evt_addr[KEY_AW-1:0] == KEY_B_ADDR) && (evt_data[7:0] == KEY_B_DATA);
  assign hit_c = (evt_addr[KEY_AW-1:0] == KEY_A_ADDR) && (evt_data[7:0] == CONFIRM_PROT);

  always_comb begin
    st_n      = st_q;
    cnt_n     = cnt_q;
    seq_eep_n = seq_eep_q;
    cmd_n     = 1'b0;
    prot_n    = 1'b0;
    ee_n      = 1'b0;
    abort_n   = 1'b0;
    load_n    = 1'b0;
    if (evt) begin
      cnt_n = '0;
      unique case (st_q)
        SQ_IDLE: begin
          if (hit_a) begin
            st_n      = SQ_KEY1;
            seq_eep_n = evt_eep;
          end else if (evt_eep && !sdp) begin
            ee_n   = 1'b1;
            load_n = 1'b1;
          end
        end
        SQ_KEY1, SQ_KEY2: begin
          if ((st_q == SQ_KEY1) && hit_b) begin
            st_n = SQ_KEY2;
          end else if ((st_q == SQ_KEY2) && hit_c) begin
            st_n  = SQ_ARMED;
            cmd_n = 1'b1;
          end else begin
            st_n = SQ_IDLE;
            if (evt_eep) begin
              ee_n   = ~sdp;
              load_n = ~sdp;
            end else begin
              abort_n = 1'b1;
            end
          end
        end
        SQ_ARMED: begin
          st_n   = SQ_IDLE;
          prot_n = 1'b1;
          load_n = 1'b1;
        end
        default: st_n = SQ_IDLE;
      endcase
    end else if (st_q != SQ_IDLE) begin
      if (cnt_q == TO_LAST) begin
        st_n    = SQ_IDLE;
        cnt_n   = '0;
        abort_n = ~seq_eep_q;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      cnt_q     <= '0;
      seq_eep_q <= 1'b0;
      cmd_ok    <= 1'b0;
      prot_wr   <= 1'b0;
      ee_wr     <= 1'b0;
      abort     <= 1'b0;
      oaddr_q   <= '0;
      odata_q   <= '0;
    end else begin
      st_q      <= st_n;
      cnt_q     <= cnt_n;
      seq_eep_q <= seq_eep_n;
      cmd_ok    <= cmd_n;
      prot_wr   <= prot_n;
      ee_wr     <= ee_n;
      abort     <= abort_n;
      if (load_n) begin
        oaddr_q <= evt_addr;
        odata_q <= evt_data;
      end
    end
  end

  assign out_addr = oaddr_q;
  assign out_data = odata_q;
endmodule

// File: rtl/ulk_sdp_ctrl.sv
module ulk_sdp_ctrl #(
  parameter int unsigned WRC_CYC = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prot_wr,
  output logic sdp
);
  localparam int unsigned CW = $clog2(WRC_CYC + 1);
  localparam logic [CW-1:0] WRC_LAST = CW'(WRC_CYC - 1);

  logic          pend_q, pend_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          sdp_q, sdp_n;

  always_comb begin
    pend_n = pend_q;
    cnt_n  = cnt_q;
    sdp_n  = sdp_q;
    if (prot_wr) begin
      pend_n = 1'b1;
      cnt_n  = '0;
    end else if (pend_q) begin
      if (cnt_q == WRC_LAST) begin
        pend_n = 1'b0;
        sdp_n  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      sdp_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
      sdp_q  <= sdp_n;
    end
  end

  assign sdp = sdp_q;
endmodule

// File: rtl/mem_unlock_decoder.sv
module mem_unlock_decoder #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TIMEOUT_CYC = 1024,
  parameter int unsigned WRC_CYC     = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_flash_n,
  input  logic              cs_eep_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              cmd_valid,
  output logic              prot_wr_en,
  output logic              read_return,
  output logic              eep_wr_stb,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              sdp_on
);
  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              evt, evt_eep;
  logic [ADDR_W-1:0] evt_addr;
  logic [DATA_W-1:0] evt_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ulk_bus_capture #(.AW(ADDR_W), .DW(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n),
    .cs_flash_n(cs_flash_n), .cs_eep_n(cs_eep_n), .we_n(we_n), .oe_n(oe_n),
    .addr_i(bus_addr), .data_i(bus_data),
    .evt(evt), .evt_eep(evt_eep), .evt_addr(evt_addr), .evt_data(evt_data)
  );

  ulk_seq_decoder #(.AW(ADDR_W), .DW(DATA_W), .TO_CYC(TIMEOUT_CYC)) u_dec (
    .clk(clk), .rst_n(rst_int_n),
    .evt(evt), .evt_eep(evt_eep), .evt_addr(evt_addr), .evt_data(evt_data),
    .sdp(sdp_on),
    .cmd_ok(cmd_valid), .prot_wr(prot_wr_en), .ee_wr(eep_wr_stb),
    .abort(read_return), .out_addr(wr_addr_o), .out_data(wr_data_o)
  );

  ulk_sdp_ctrl #(.WRC_CYC(WRC_CYC)) u_sdp (
    .clk(clk), .rst_n(rst_int_n), .prot_wr(prot_wr_en), .sdp(sdp_on)
  );
endmodule

// File: rtl/mem_unlock_checker.sv
module mem_unlock_checker (
  input logic clk,
  input logic rst_n,
  input logic cs_flash_n,
  input logic cs_eep_n,
  input logic we_n,
  input logic oe_n,
  input logic cmd_valid,
  input logic prot_wr_en,
  input logic read_return,
  input logic eep_wr_stb,
  input logic sdp_on
);
  logic bus_act;
  logic armed_q;

  assign bus_act = (cs_flash_n ^ cs_eep_n) & ~we_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed_q <= 1'b0;
    else if (cmd_valid)  armed_q <= 1'b1;
    else if (prot_wr_en) armed_q <= 1'b0;
  end

  AST_STROBE_AFTER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (eep_wr_stb || prot_wr_en || cmd_valid) |-> ($past(bus_act, 2) && !$past(bus_act))); // R1
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eep_wr_stb, prot_wr_en, cmd_valid, read_return})); // R4
  AST_PROT_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    prot_wr_en |-> armed_q); // R5
  AST_SDP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sdp_on |=> sdp_on); // R9
  AST_NO_EE_UNDER_SDP: assert property (@(posedge clk) disable iff (!rst_n)
    eep_wr_stb |-> !$past(sdp_on)); // R10
endmodule

bind mem_unlock_decoder mem_unlock_checker i_chk (
  .clk(clk), .rst_n(rst_n),
  .cs_flash_n(cs_flash_n), .cs_eep_n(cs_eep_n), .we_n(we_n), .oe_n(oe_n),
  .cmd_valid(cmd_valid), .prot_wr_en(prot_wr_en), .read_return(read_return),
  .eep_wr_stb(eep_wr_stb), .sdp_on(sdp_on)
);

// File: tb/test_mem_unlock_decoder.sv
module test_mem_unlock_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int TO = 40;
  localparam int WRC = 6;

  typedef struct packed {
    logic          eep;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic          x_ee;
    logic          x_prot;
    logic          x_cmd;
    logic          x_abort;
    logic          x_sdp;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 16'h0123, 8'h5A, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 plain eeprom
    '{1'b0, 16'h0456, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R12 plain flash
    '{1'b0, 16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b0, 16'h1234, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 wrong addr
    '{1'b1, 16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'h0777, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 pass through
    '{1'b0, 16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'h5555, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}, // R6 wrong value
    '{1'b0, 16'h5555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{1'b0, 16'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R3
    '{1'b1, 16'h0042, 8'h99, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R5 R9
    '{1'b1, 16'h0100, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R10
    '{1'b1, 16'hD555, 8'hAA, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R3 top bit ignored
    '{1'b1, 16'hAAAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b1, 16'h5555, 8'hA0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b1, 16'h0100, 8'h66, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b1, 16'h2AAA, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}  // R10
  };

  logic          clk;
  logic          rst_n;
  logic          cs_flash_n, cs_eep_n, we_n, oe_n;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_data;
  logic          cmd_valid, prot_wr_en, read_return, eep_wr_stb, sdp_on;
  logic [AW-1:0] wr_addr_o;
  logic [DW-1:0] wr_data_o;

  int n_chk, n_fail;
  int n_ee, n_prot, n_cmd, n_abort;
  logic [AW-1:0] last_addr;
  logic [DW-1:0] last_data;
  bit done;

  mem_unlock_decoder #(.ADDR_W(AW), .DATA_W(DW), .TIMEOUT_CYC(TO), .WRC_CYC(WRC))
    i_mem_unlock_decoder (
      .clk(clk), .rst_n(rst_n),
      .cs_flash_n(cs_flash_n), .cs_eep_n(cs_eep_n), .we_n(we_n), .oe_n(oe_n),
      .bus_addr(bus_addr), .bus_data(bus_data),
      .cmd_valid(cmd_valid), .prot_wr_en(prot_wr_en), .read_return(read_return),
      .eep_wr_stb(eep_wr_stb), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
      .sdp_on(sdp_on)
    );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (eep_wr_stb)  n_ee++;
    if (prot_wr_en)  n_prot++;
    if (cmd_valid)   n_cmd++;
    if (read_return) n_abort++;
    if (eep_wr_stb || prot_wr_en) begin
      last_addr = wr_addr_o;
      last_data = wr_data_o;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // rgn: 0 flash, 1 eeprom, 2 both selects
  task automatic bus_wr_x(input logic [1:0] rgn, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                          input logic [AW-1:0] a1, input logic [DW-1:0] d1, input logic oe_lvl);
    @(negedge clk);
    bus_addr   = a0;
    bus_data   = d0;
    oe_n       = oe_lvl;
    cs_flash_n = (rgn == 2'd1);
    cs_eep_n   = (rgn == 2'd0);
    @(negedge clk);
    we_n = 1'b0;
    repeat (2) @(negedge clk);
    bus_addr = a1;
    bus_data = d1;
    repeat (2) @(negedge clk);
    we_n = 1'b1;
    @(negedge clk);
    cs_flash_n = 1'b1;
    cs_eep_n   = 1'b1;
    oe_n       = 1'b1;
  endtask

  task automatic bus_wr(input logic eep, input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_wr_x({1'b0, eep}, a, d, a, d, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int e0, p0, c0, a0;
    n_chk = 0; n_fail = 0; n_ee = 0; n_prot = 0; n_cmd = 0; n_abort = 0;
    done = 1'b0;
    rst_n = 1'b0;
    cs_flash_n = 1'b1; cs_eep_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    bus_addr = '0; bus_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 reset sdp", {31'd0, sdp_on}, 32'd0);
    chk("R11 reset pulses", {28'd0, eep_wr_stb, prot_wr_en, cmd_valid, read_return}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      e0 = n_ee; p0 = n_prot; c0 = n_cmd; a0 = n_abort;
      bus_wr(VEC[i].eep, VEC[i].addr, VEC[i].data);
      repeat (10) @(negedge clk);
      chk($sformatf("R12/R7/R10 ee vec%0d", i), n_ee - e0, {31'd0, VEC[i].x_ee});
      chk($sformatf("R5 prot vec%0d", i), n_prot - p0, {31'd0, VEC[i].x_prot});
      chk($sformatf("R3 cmd vec%0d", i), n_cmd - c0, {31'd0, VEC[i].x_cmd});
      chk($sformatf("R6 abort vec%0d", i), n_abort - a0, {31'd0, VEC[i].x_abort});
      chk($sformatf("R9 sdp vec%0d", i), {31'd0, sdp_on}, {31'd0, VEC[i].x_sdp});
      if (VEC[i].x_ee || VEC[i].x_prot) begin
        chk($sformatf("R2 addr vec%0d", i), {16'd0, last_addr}, {16'd0, VEC[i].addr});
        chk($sformatf("R2 data vec%0d", i), {24'd0, last_data}, {24'd0, VEC[i].data});
      end
    end

    // R8 flash time-out gives read_return, sequence lost
    a0 = n_abort; c0 = n_cmd;
    bus_wr(1'b0, 16'h5555, 8'hAA);
    repeat (60) @(negedge clk);
    chk("R8 flash timeout abort", n_abort - a0, 32'd1);
    bus_wr(1'b0, 16'h2AAA, 8'h55);
    bus_wr(1'b0, 16'h5555, 8'hA0);
    repeat (5) @(negedge clk);
    chk("R8 flash timeout no cmd", n_cmd - c0, 32'd0);

    // R8 eeprom time-out: silent
    a0 = n_abort; c0 = n_cmd;
    bus_wr(1'b1, 16'h5555, 8'hAA);
    repeat (60) @(negedge clk);
    chk("R8 eep timeout no abort", n_abort - a0, 32'd0);
    bus_wr(1'b1, 16'h2AAA, 8'h55);
    bus_wr(1'b1, 16'h5555, 8'hA0);
    repeat (5) @(negedge clk);
    chk("R8 eep timeout no cmd", n_cmd - c0, 32'd0);

    // R2 address from start, data from end of cycle
    p0 = n_prot;
    bus_wr(1'b0, 16'h5555, 8'hAA);
    bus_wr(1'b0, 16'h2AAA, 8'h55);
    bus_wr(1'b0, 16'h5555, 8'hA0);
    bus_wr_x(2'd1, 16'h0300, 8'h11, 16'h0301, 8'h22, 1'b1);
    repeat (5) @(negedge clk);
    chk("R5 prot after prefix", n_prot - p0, 32'd1);
    chk("R2 start addr", {16'd0, last_addr}, 32'h0300);
    chk("R2 end data", {24'd0, last_data}, 32'h22);

    // R11 reset clears protection
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 sdp cleared", {31'd0, sdp_on}, 32'd0);

    // R1 output enable low and dual select produce nothing
    e0 = n_ee;
    bus_wr_x(2'd1, 16'h0010, 8'h33, 16'h0010, 8'h33, 1'b0);
    repeat (5) @(negedge clk);
    chk("R1 oe low ignored", n_ee - e0, 32'd0);
    bus_wr_x(2'd2, 16'h0011, 8'h44, 16'h0011, 8'h44, 1'b1);
    repeat (5) @(negedge clk);
    chk("R1 both selects ignored", n_ee - e0, 32'd0);
    bus_wr(1'b1, 16'h0012, 8'h55);
    repeat (5) @(negedge clk);
    chk("R11 R12 write after reset", n_ee - e0, 32'd1);
    chk("R12 addr after reset", {16'd0, last_addr}, 32'h0012);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule